// File: doc/BRIEF.md
# Three-Operand Load/Store Sequencer Core

This block is a small multi-cycle processor. It runs a fixed program held in an external instruction store. A program counter drives the fetch address, and each fetched word is decoded into one of five operations: load an immediate, load a word from data memory, store a register to data memory, add two registers, or multiply two registers. Every result enters a four-entry register file through a single write port. That port takes its value from the arithmetic unit, the immediate field or returned load data. A store places register A on a dedicated store-data path.

Data memory is reached over split read and write channels. A read request carries an address. The memory answers one clock later, which models a synchronous RAM. A write is a one-cycle strobe that carries an address and a data word. A halt opcode freezes the program counter and raises `done`. The core then stays idle until reset. Instructions run strictly one at a time and in program order. Nothing overlaps.

Top module: `cpu3_core`

## Requirements
- R1: While reset is high and in the cycle after it, the fetch address is 0 and `done`, `st_en` and `ld_req` are low. All four registers are reset to zero.
- R2: An instruction word is 25 bits: opcode in [24:22], destination register in [21:20], source A in [19:18], source B in [17:16], immediate/address in [15:0]. Load-immediate (opcode 1) writes the 16-bit field zero-extended to 32 bits into the destination.
- R3: Add (opcode 4) writes source A plus source B, modulo 2^32, into the destination.
- R4: Multiply (opcode 5) writes the low 32 bits of source A times source B into the destination.
- R5: Load (opcode 2) raises `ld_req` for exactly one cycle, with `ld_addr` equal to the immediate field. The word on `ld_data` in the following cycle is written into the destination.
- R6: Store (opcode 3) raises `st_en` for exactly one cycle, with `st_addr` equal to the immediate field and `st_data` equal to source A.
- R7: Load takes three cycles and every other instruction takes two. Fetch addresses advance by one per instruction, in program order. `ld_req` and `st_en` are never high together.
- R8: Halt (opcode 0), and the unused opcodes 6 and 7, set `done` two cycles after the halt word is fetched. From then on the fetch address holds, `done` stays high, and no load or store strobe is raised.
- R9: When the destination equals a source, the source values used are those from before the write.
- R10: The program R0=M[100]; R1=M[101]; R2=#42; R2=R1*R2; R0=R2+R0; M[100]=R0; halt leaves M[100] equal to its old value plus 42 times M[101], and `done` is reached after 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Instruction fetch address (program counter) |
| imem_data | input | 25 | Instruction word at `imem_addr`, combinational |
| ld_req | output | 1 | Data read request |
| ld_addr | output | 16 | Data read address |
| ld_data | input | DATA_W | Read data, valid the cycle after `ld_req` |
| st_en | output | 1 | Data write strobe |
| st_addr | output | 16 | Data write address |
| st_data | output | DATA_W | Data write value (source register A) |
| done | output | 1 | High once a halt has executed |

## Verification
In the execute cycle, a register-file read and a write to the same register can fall in the same cycle. Examples are R1=R1+R1 and R3=R3*R3, where the arithmetic result is written back on the edge that closes the cycle in which both sources are read. Directed programs contain such self-referencing adds and multiplies. Constrained-random programs draw destination and source fields from a pool of only four registers, so such collisions occur often. Every result is then stored to memory. The final memory image, the strobe counts and the cycle count are compared against a bench-side instruction model that always reads sources before writing.

// File: rtl/cpu3_pkg.sv
package cpu3_pkg;

    localparam int OPC_W  = 3;
    localparam int RSEL_W = 2;
    localparam int IMM_W  = 16;
    localparam int INSN_W = OPC_W + 3 * RSEL_W + IMM_W;
    localparam int NREG   = 1 << RSEL_W;

    typedef enum logic [OPC_W-1:0] {
        OPC_HALT = 3'd0,
        OPC_LDI  = 3'd1,
        OPC_LD   = 3'd2,
        OPC_ST   = 3'd3,
        OPC_ADD  = 3'd4,
        OPC_MUL  = 3'd5,
        OPC_RSV6 = 3'd6,
        OPC_RSV7 = 3'd7
    } opc_e;

    typedef struct packed {
        opc_e              opc;
        logic [RSEL_W-1:0] rc;
        logic [RSEL_W-1:0] ra;
        logic [RSEL_W-1:0] rb;
        logic [IMM_W-1:0]  imm;
    } insn_t;

    typedef enum logic [1:0] {
        PH_FETCH,
        PH_EXEC,
        PH_LOAD,
        PH_HALT
    } phase_e;

    typedef enum logic [1:0] {
        WSRC_ALU,
        WSRC_IMM,
        WSRC_MEM
    } wsrc_e;

    typedef enum logic {
        ALU_ADD,
        ALU_MUL
    } alu_op_e;

    typedef struct packed {
        logic    rf_we;
        wsrc_e   wsrc;
        alu_op_e alu_op;
        logic    st_en;
        logic    ld_req;
        logic    go_load;
        logic    halt;
    } ctl_t;

    function automatic ctl_t ctl_idle();
        ctl_t c;
        c.rf_we   = 1'b0;
        c.wsrc    = WSRC_ALU;
        c.alu_op  = ALU_ADD;
        c.st_en   = 1'b0;
        c.ld_req  = 1'b0;
        c.go_load = 1'b0;
        c.halt    = 1'b0;
        return c;
    endfunction

    // Execute-phase controls for one opcode. Unused codes behave as halt.
    function automatic ctl_t decode_exec(opc_e op);
        ctl_t c;
        c = ctl_idle();
        case (op)
            OPC_LDI: begin
                c.rf_we = 1'b1;
                c.wsrc  = WSRC_IMM;
            end
            OPC_LD: begin
                c.ld_req  = 1'b1;
                c.go_load = 1'b1;
            end
            OPC_ST: c.st_en = 1'b1;
            OPC_ADD: begin
                c.rf_we  = 1'b1;
                c.wsrc   = WSRC_ALU;
                c.alu_op = ALU_ADD;
            end
            OPC_MUL: begin
                c.rf_we  = 1'b1;
                c.wsrc   = WSRC_ALU;
                c.alu_op = ALU_MUL;
            end
            default: c.halt = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cpu3_regfile.sv
module cpu3_regfile
    import cpu3_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = NREG,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel_a,
    input  logic [SEL_W-1:0]  sel_b,
    output logic [DATA_W-1:0] val_a,
    output logic [DATA_W-1:0] val_b,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel_c,
    input  logic [DATA_W-1:0] val_c
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            cells[sel_c] <= val_c;
        end
    end

    // Reads see the value before any write on the closing edge.
    assign val_a = cells[sel_a];
    assign val_b = cells[sel_b];

endmodule

// File: rtl/cpu3_alu.sv
module cpu3_alu
    import cpu3_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int PROD_W = 2 * DATA_W
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] res
);

    logic [PROD_W-1:0] prod;
    logic [DATA_W-1:0] sum;

    assign prod = PROD_W'(lhs) * PROD_W'(rhs);
    assign sum  = lhs + rhs;

    always_comb begin
        case (op)
            ALU_MUL: res = prod[DATA_W-1:0];
            default: res = sum;
        endcase
    end

endmodule

// File: rtl/cpu3_ctrl.sv
module cpu3_ctrl
    import cpu3_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  insn_t           fetch_word,
    output logic [PC_W-1:0] pc,
    output insn_t           ir,
    output phase_e          phase,
    output ctl_t            ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            ir    <= '0;
            phase <= PH_FETCH;
        end else begin
            case (phase)
                PH_FETCH: begin
                    ir    <= fetch_word;
                    phase <= PH_EXEC;
                end
                PH_EXEC: begin
                    if (ctl.halt) begin
                        phase <= PH_HALT;
                    end else if (ctl.go_load) begin
                        phase <= PH_LOAD;
                    end else begin
                        pc    <= pc + PC_W'(1);
                        phase <= PH_FETCH;
                    end
                end
                PH_LOAD: begin
                    pc    <= pc + PC_W'(1);
                    phase <= PH_FETCH;
                end
                default: phase <= PH_HALT;
            endcase
        end
    end

    always_comb begin
        ctl = ctl_idle();
        case (phase)
            PH_EXEC: ctl = decode_exec(ir.opc);
            PH_LOAD: begin
                ctl.rf_we = 1'b1;
                ctl.wsrc  = WSRC_MEM;
            end
            default: ctl = ctl_idle();
        endcase
    end

endmodule

// File: rtl/cpu3_core.sv
module cpu3_core
    import cpu3_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [INSN_W-1:0] imem_data,
    output logic              ld_req,
    output logic [IMM_W-1:0]  ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              st_en,
    output logic [IMM_W-1:0]  st_addr,
    output logic [DATA_W-1:0] st_data,
    output logic              done
);

    insn_t             ir;
    phase_e            phase;
    ctl_t              ctl;
    logic [PC_W-1:0]   pc;
    logic [DATA_W-1:0] src_a;
    logic [DATA_W-1:0] src_b;
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] wr_val;

    cpu3_ctrl #(.PC_W(PC_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .fetch_word (insn_t'(imem_data)),
        .pc         (pc),
        .ir         (ir),
        .phase      (phase),
        .ctl        (ctl)
    );

    cpu3_regfile #(.DATA_W(DATA_W), .DEPTH(NREG)) rf_i (
        .clk   (clk),
        .rst   (rst),
        .sel_a (ir.ra),
        .sel_b (ir.rb),
        .val_a (src_a),
        .val_b (src_b),
        .wr_en (ctl.rf_we),
        .sel_c (ir.rc),
        .val_c (wr_val)
    );

    cpu3_alu #(.DATA_W(DATA_W)) alu_i (
        .op  (ctl.alu_op),
        .lhs (src_a),
        .rhs (src_b),
        .res (alu_res)
    );

    always_comb begin
        case (ctl.wsrc)
            WSRC_IMM: wr_val = DATA_W'(ir.imm);
            WSRC_MEM: wr_val = ld_data;
            default:  wr_val = alu_res;
        endcase
    end

    assign imem_addr = pc;
    assign ld_req    = ctl.ld_req;
    assign ld_addr   = ir.imm;
    assign st_en     = ctl.st_en;
    assign st_addr   = ir.imm;
    assign st_data   = src_a;
    assign done      = (phase == PH_HALT);

endmodule

// File: rtl/cpu3_core_chk.sv
module cpu3_core_chk #(
    parameter int PC_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] imem_addr,
    input logic            ld_req,
    input logic            st_en,
    input logic            done
);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ld_req && !st_en));

    // R8
    halt_pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(imem_addr));

    // R5
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ld_req |=> !ld_req);

    // R6
    store_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        st_en |=> !st_en);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ld_req && st_en));

    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (imem_addr == $past(imem_addr)
                  || imem_addr == $past(imem_addr) + PC_W'(1)));

endmodule

bind cpu3_core cpu3_core_chk #(.PC_W(PC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .ld_req    (ld_req),
    .st_en     (st_en),
    .done      (done)
);

// File: tb/cpu3_core_tb_top.sv
module cpu3_core_tb_top;

    localparam int CLK_P   = 10;
    localparam int PC_W    = 8;
    localparam int DATA_W  = 32;
    localparam int IW      = 25;
    localparam int MEMN    = 256;
    localparam int RUN_MAX = 3000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PC_W-1:0]   imem_addr;
    logic [IW-1:0]     imem_data;
    logic              ld_req;
    logic [15:0]       ld_addr;
    logic [DATA_W-1:0] ld_data;
    logic              st_en;
    logic [15:0]       st_addr;
    logic [DATA_W-1:0] st_data;
    logic              done;

    logic [IW-1:0]     imem     [MEMN];
    logic [DATA_W-1:0] dmem     [MEMN];
    logic [DATA_W-1:0] init_mem [MEMN];
    logic [DATA_W-1:0] exp_mem  [MEMN];

    int n_cmp = 0;
    int n_bad = 0;
    int n_st  = 0;
    int n_ld  = 0;
    int exp_cyc, exp_st, exp_ld, exp_hpc;

    always #(CLK_P/2) clk = ~clk;

    cpu3_core #(.DATA_W(DATA_W), .PC_W(PC_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .ld_req    (ld_req),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .st_en     (st_en),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .done      (done)
    );

    assign imem_data = imem[imem_addr];

    always @(posedge clk) begin
        if (st_en) dmem[st_addr[7:0]] <= st_data;
        ld_data <= dmem[ld_addr[7:0]];
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (st_en) n_st++;
            if (ld_req) n_ld++;
        end
    end

    function automatic logic [IW-1:0] enc(input int op, input int rc, input int ra,
                                          input int rb, input int imm);
        return {3'(op), 2'(rc), 2'(ra), 2'(rb), 16'(imm)};
    endfunction

    task automatic check(input string req, input logic ok, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Instruction-level model: sources read before the destination is written.
    task automatic model_run();
        logic [DATA_W-1:0] r [4];
        logic [63:0] p;
        int pc = 0;
        for (int i = 0; i < 4; i++) r[i] = '0;
        for (int i = 0; i < MEMN; i++) exp_mem[i] = init_mem[i];
        exp_cyc = 0; exp_st = 0; exp_ld = 0; exp_hpc = 0;
        while (1) begin
            logic [IW-1:0] w = imem[pc];
            int op = int'(w[24:22]);
            int rc = int'(w[21:20]);
            int ra = int'(w[19:18]);
            int rb = int'(w[17:16]);
            logic [15:0] im = w[15:0];
            if (op == 1) begin r[rc] = DATA_W'(im); exp_cyc += 2; end
            else if (op == 2) begin r[rc] = exp_mem[im[7:0]]; exp_cyc += 3; exp_ld++; end
            else if (op == 3) begin exp_mem[im[7:0]] = r[ra]; exp_cyc += 2; exp_st++; end
            else if (op == 4) begin r[rc] = r[ra] + r[rb]; exp_cyc += 2; end
            else if (op == 5) begin
                p = 64'(r[ra]) * 64'(r[rb]);
                r[rc] = p[31:0];
                exp_cyc += 2;
            end else begin
                exp_cyc += 2; exp_hpc = pc; break;
            end
            pc++;
        end
    endtask

    task automatic run_prog(input string tag);
        int cyc = 0;
        int bad_i = -1;
        logic [PC_W-1:0] hold;
        logic quiet;
        model_run();
        for (int i = 0; i < MEMN; i++) dmem[i] = init_mem[i];
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1
        check({"R1 reset ", tag}, imem_addr == 0 && !done && !st_en && !ld_req,
              {imem_addr, done, st_en, ld_req}, 0);
        n_st = 0; n_ld = 0;
        rst = 1'b0;
        while (cyc < RUN_MAX) begin
            @(posedge clk); #1;
            cyc++;
            if (done) break;
        end
        // R7 cycle budget and watchdog
        check({"R7 cycles ", tag}, done && cyc == exp_cyc, cyc, exp_cyc);
        check({"R5 load count ", tag}, n_ld == exp_ld, n_ld, exp_ld);
        check({"R6 store count ", tag}, n_st == exp_st, n_st, exp_st);
        check({"R8 halt pc ", tag}, imem_addr == PC_W'(exp_hpc), imem_addr, exp_hpc);
        @(negedge clk);
        for (int i = 0; i < MEMN; i++) begin
            if (bad_i < 0 && dmem[i] !== exp_mem[i]) bad_i = i;
        end
        // R2 R3 R4 R9 memory image
        check({"R2/R3/R4/R9 memory ", tag}, bad_i < 0,
              bad_i < 0 ? 0 : dmem[bad_i], bad_i < 0 ? 0 : exp_mem[bad_i]);
        hold = imem_addr;
        quiet = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (imem_addr != hold || !done || st_en || ld_req) quiet = 1'b0;
        end
        // R8
        check({"R8 idle after halt ", tag}, quiet, imem_addr, hold);
    endtask

    task automatic clear_all();
        for (int i = 0; i < MEMN; i++) begin
            imem[i] = '0;
            init_mem[i] = '0;
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_c3a1));

        // R10 example accumulate program
        clear_all();
        init_mem[100] = 32'd1000;
        init_mem[101] = 32'd7;
        imem[0] = enc(2, 0, 0, 0, 100);
        imem[1] = enc(2, 1, 0, 0, 101);
        imem[2] = enc(1, 2, 0, 0, 42);
        imem[3] = enc(5, 2, 1, 2, 0);
        imem[4] = enc(4, 0, 2, 0, 0);
        imem[5] = enc(3, 0, 0, 0, 100);
        imem[6] = enc(0, 0, 0, 0, 0);
        run_prog("example");
        // R10
        check("R10 mem100", dmem[100] == 32'd1294, dmem[100], 1294);
        check("R10 cycles", exp_cyc == 16, exp_cyc, 16);

        // R2 zero extension, R3/R4/R9 self-referencing ops, R4 overflow
        clear_all();
        init_mem[10] = 32'h89AB_CDEF;
        imem[0] = enc(1, 1, 0, 0, 16'hFFFF);
        imem[1] = enc(3, 0, 1, 0, 5);
        imem[2] = enc(5, 1, 1, 1, 0);
        imem[3] = enc(3, 0, 1, 0, 6);
        imem[4] = enc(4, 1, 1, 1, 0);
        imem[5] = enc(3, 0, 1, 0, 7);
        imem[6] = enc(2, 3, 0, 0, 10);
        imem[7] = enc(5, 3, 3, 3, 0);
        imem[8] = enc(3, 0, 3, 0, 8);
        imem[9] = enc(3, 0, 2, 0, 9);
        imem[10] = enc(0, 0, 0, 0, 0);
        run_prog("directed");
        // R2
        check("R2 zero-extended imm", dmem[5] == 32'h0000_FFFF, dmem[5], 32'h0000_FFFF);
        // R4 R9
        check("R4 square low bits", dmem[6] == 32'hFFFE_0001, dmem[6], 32'hFFFE_0001);
        // R3 R9
        check("R3 self add", dmem[7] == 32'hFFFC_0002, dmem[7], 32'hFFFC_0002);
        // R1 untouched register reads zero
        check("R1 reg reset zero", dmem[9] == 0, dmem[9], 0);

        // R8 unused opcode halts
        clear_all();
        init_mem[9] = 32'hA5A5_0001;
        imem[0] = enc(1, 0, 0, 0, 5);
        imem[1] = enc(7, 0, 0, 0, 0);
        imem[2] = enc(3, 0, 0, 0, 9);
        imem[3] = enc(0, 0, 0, 0, 0);
        run_prog("rsv-halt");
        // R8
        check("R8 no store past opcode 7", dmem[9] == 32'hA5A5_0001, dmem[9], 32'hA5A5_0001);

        // Constrained random programs
        for (int t = 0; t < 20; t++) begin
            clear_all();
            for (int i = 0; i < MEMN; i++) init_mem[i] = $urandom;
            for (int i = 0; i < 14; i++) begin
                int op = 1 + int'($urandom_range(4, 0));
                int imm = (op == 1) ? int'($urandom_range(65535, 0))
                                    : int'($urandom_range(MEMN - 1, 0));
                imem[i] = enc(op, int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
                              int'($urandom_range(3, 0)), imm);
            end
            imem[14] = enc(0, 0, 0, 0, 0);
            run_prog($sformatf("rand%0d", t));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule